// File: doc/BRIEF.md
# Block Truncation Bit-Plane Encoder

The encoder takes 8-bit gray pixels, one for each accepted valid strobe, and collects them into blocks of sixteen (a 4x4 tile, already in raster order within the tile). When the sixteenth pixel arrives, the pixel sum is shifted right to give the truncated block mean. The stored pixels are then walked one per cycle. Each pixel is compared against the mean and gets one bit in a 16-bit bit plane. The walk also keeps a running sum and count for the pixels below the mean and for the pixels at or above it.

When the walk ends, the encoder registers the bit plane, the two class sums and the two class counts, and raises a one-cycle done pulse. A downstream stage divides each sum by its count to get the two reconstruction levels. The input side takes pixels again in the same cycle as the done pulse. Loading of the next block therefore overlaps that downstream division.

Top module: `btc_encoder`

## Requirements
- R1: After the asynchronous active-low reset, pix_ready_o is 1, done_o is 0, and bitmap_o, both sums and both counts are 0.
- R2: The threshold is the truncated mean, floor(sum of the 16 pixels / 16). A pixel below the threshold is coded 0 and any other pixel is coded 1, so a pixel equal to the mean is coded 1.
- R3: Bit i of bitmap_o (bit 0 is the LSB) belongs to the i-th pixel accepted within the block, counting from 0.
- R4: lo_sum_o and lo_cnt_o are the sum and number of the 0-coded pixels. hi_sum_o and hi_cnt_o are the sum and number of the 1-coded pixels. The two counts always add up to 16.
- R5: A pixel is accepted only on a clock edge where pix_valid_i and pix_ready_o are both 1. Strobes while pix_ready_o is 0 have no effect on any block.
- R6: done_o is high for exactly one cycle, 16 cycles after the edge that accepts the sixteenth pixel. Between done pulses, all result outputs hold their values.
- R7: pix_ready_o goes low after the edge that accepts the sixteenth pixel and goes high again in the cycle where done_o is high. The first pixel of the next block can therefore be taken in that cycle.
- R8: Idle cycles between pixels inside a block do not change the result. Blocks may also follow each other back to back with pix_valid_i held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_i | input | 8 | Gray pixel value |
| pix_ready_o | output | 1 | Encoder can take a pixel this cycle |
| done_o | output | 1 | One-cycle pulse: results updated |
| bitmap_o | output | 16 | Bit plane, bit i for pixel i |
| lo_sum_o | output | 12 | Sum of 0-coded pixels |
| lo_cnt_o | output | 5 | Count of 0-coded pixels |
| hi_sum_o | output | 12 | Sum of 1-coded pixels |
| hi_cnt_o | output | 5 | Count of 1-coded pixels |

## Verification
Flat blocks at 0, 100 and 255 put every pixel exactly on the mean. These separate a greater-or-equal compare from a strict one, and the 255 block also checks that the full 12-bit sum fits. A block of fifteen 10s and one 25 has a mean of 10.94, so it separates truncation from rounding. A lone bright outlier and a ramp check the bit order and the class sums. Random blocks are sent both with gaps and back to back, and junk strobes are driven while the encoder is busy. Together these show that the next block starts in the done cycle and that ignored pixels never leak into a block.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WALK = 1'b1
  } walk_ph_e;
endpackage

// File: rtl/btc_pix_store.sv
module btc_pix_store #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [PIX_W-1:0]         wr_data_i,
  input  logic [$clog2(NPIX)-1:0]  rd_idx_i,
  output logic [PIX_W-1:0]         rd_data_o,
  output logic                     full_o,
  output logic [PIX_W-1:0]         mean_o
);
  localparam int IDX_W = $clog2(NPIX);
  localparam int SUM_W = PIX_W + IDX_W;

  logic [IDX_W-1:0] wr_ptr_q;
  logic [SUM_W-1:0] sum_q, sum_nxt;
  logic [PIX_W-1:0] mean_q;
  logic [PIX_W-1:0] mem_q [NPIX];

  assign sum_nxt = sum_q + SUM_W'(wr_data_i);
  assign full_o  = wr_en_i && (wr_ptr_q == IDX_W'(NPIX-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      sum_q    <= '0;
      mean_q   <= '0;
    end else if (wr_en_i) begin
      if (full_o) begin
        wr_ptr_q <= '0;
        sum_q    <= '0;
        mean_q   <= sum_nxt[SUM_W-1:IDX_W]; // divide by NPIX, truncated
      end else begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
        sum_q    <= sum_nxt;
      end
    end
  end

  for (genvar e = 0; e < NPIX; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[e] <= '0;
      else if (wr_en_i && wr_ptr_q == IDX_W'(e))     mem_q[e] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign mean_o    = mean_q;

  a_r5_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_q));
endmodule

// File: rtl/btc_classify.sv
module btc_classify
  import btc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [PIX_W-1:0]               mean_i,
  input  logic [PIX_W-1:0]               pix_i,
  output logic [$clog2(NPIX)-1:0]        rd_idx_o,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [NPIX-1:0]                bitmap_o,
  output logic [PIX_W+$clog2(NPIX)-1:0]  lo_sum_o,
  output logic [$clog2(NPIX):0]          lo_cnt_o,
  output logic [PIX_W+$clog2(NPIX)-1:0]  hi_sum_o,
  output logic [$clog2(NPIX):0]          hi_cnt_o
);
  localparam int IDX_W = $clog2(NPIX);
  localparam int SUM_W = PIX_W + IDX_W;
  localparam int CNT_W = IDX_W + 1;

  walk_ph_e         ph_q;
  logic [IDX_W-1:0] idx_q;
  logic [NPIX-1:0]  bm_q, bm_nxt;
  logic [SUM_W-1:0] lo_sum_q, hi_sum_q, lo_sum_nxt, hi_sum_nxt;
  logic [CNT_W-1:0] lo_cnt_q, hi_cnt_q, lo_cnt_nxt, hi_cnt_nxt;
  logic             bit_hi, last;

  assign bit_hi = (pix_i >= mean_i);
  assign last   = (idx_q == IDX_W'(NPIX-1));

  always_comb begin
    bm_nxt        = bm_q;
    bm_nxt[idx_q] = bit_hi;
    lo_sum_nxt    = lo_sum_q;
    lo_cnt_nxt    = lo_cnt_q;
    hi_sum_nxt    = hi_sum_q;
    hi_cnt_nxt    = hi_cnt_q;
    if (bit_hi) begin
      hi_sum_nxt = hi_sum_q + SUM_W'(pix_i);
      hi_cnt_nxt = hi_cnt_q + 1'b1;
    end else begin
      lo_sum_nxt = lo_sum_q + SUM_W'(pix_i);
      lo_cnt_nxt = lo_cnt_q + 1'b1;
    end
  end

  // working accumulators
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      idx_q    <= '0;
      bm_q     <= '0;
      lo_sum_q <= '0;
      lo_cnt_q <= '0;
      hi_sum_q <= '0;
      hi_cnt_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_q     <= PH_WALK;
        idx_q    <= '0;
        bm_q     <= '0;
        lo_sum_q <= '0;
        lo_cnt_q <= '0;
        hi_sum_q <= '0;
        hi_cnt_q <= '0;
      end
    end else begin
      bm_q     <= bm_nxt;
      lo_sum_q <= lo_sum_nxt;
      lo_cnt_q <= lo_cnt_nxt;
      hi_sum_q <= hi_sum_nxt;
      hi_cnt_q <= hi_cnt_nxt;
      idx_q    <= idx_q + 1'b1;
      if (last) ph_q <= PH_IDLE;
    end
  end

  // result registers, updated once per block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      bitmap_o <= '0;
      lo_sum_o <= '0;
      lo_cnt_o <= '0;
      hi_sum_o <= '0;
      hi_cnt_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (ph_q == PH_WALK && last) begin
        done_o   <= 1'b1;
        bitmap_o <= bm_nxt;
        lo_sum_o <= lo_sum_nxt;
        lo_cnt_o <= lo_cnt_nxt;
        hi_sum_o <= hi_sum_nxt;
        hi_cnt_o <= hi_cnt_nxt;
      end
    end
  end

  assign rd_idx_o = idx_q;
  assign busy_o   = (ph_q == PH_WALK);

  // R2: every 1-coded pixel is at or above the mean held in the store
  a_r2_hi_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(hi_sum_o) >= 32'(hi_cnt_o) * 32'(mean_i)));
  // R2: every 0-coded pixel is below it
  a_r2_lo_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && lo_cnt_o != '0) |-> (32'(lo_sum_o) < 32'(lo_cnt_o) * 32'(mean_i)));
endmodule

// File: rtl/btc_encoder.sv
module btc_encoder #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           pix_valid_i,
  input  logic [PIX_W-1:0]               pix_i,
  output logic                           pix_ready_o,
  output logic                           done_o,
  output logic [NPIX-1:0]                bitmap_o,
  output logic [PIX_W+$clog2(NPIX)-1:0]  lo_sum_o,
  output logic [$clog2(NPIX):0]          lo_cnt_o,
  output logic [PIX_W+$clog2(NPIX)-1:0]  hi_sum_o,
  output logic [$clog2(NPIX):0]          hi_cnt_o
);
  localparam int IDX_W = $clog2(NPIX);

  logic             wr_en, full, busy;
  logic [IDX_W-1:0] rd_idx;
  logic [PIX_W-1:0] rd_data, mean;

  assign pix_ready_o = !busy;
  assign wr_en       = pix_valid_i && pix_ready_o;

  btc_pix_store #(.PIX_W(PIX_W), .NPIX(NPIX)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (pix_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .full_o    (full),
    .mean_o    (mean)
  );

  btc_classify #(.PIX_W(PIX_W), .NPIX(NPIX)) u_cls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (full),
    .mean_i   (mean),
    .pix_i    (rd_data),
    .rd_idx_o (rd_idx),
    .busy_o   (busy),
    .done_o   (done_o),
    .bitmap_o (bitmap_o),
    .lo_sum_o (lo_sum_o),
    .lo_cnt_o (lo_cnt_o),
    .hi_sum_o (hi_sum_o),
    .hi_cnt_o (hi_cnt_o)
  );

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_ready_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pix_ready_o);
  a_r4_count_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(lo_cnt_o) + 32'(hi_cnt_o) == NPIX));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({bitmap_o, lo_sum_o, lo_cnt_o, hi_sum_o, hi_cnt_o}));
endmodule

// File: tb/tb_btc_encoder.sv
module tb_btc_encoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_i = '0;
  logic        pix_ready_o, done_o;
  logic [15:0] bitmap_o;
  logic [11:0] lo_sum_o, hi_sum_o;
  logic [4:0]  lo_cnt_o, hi_cnt_o;

  always #5 clk = ~clk;

  btc_encoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_valid_i(pix_valid_i), .pix_i(pix_i),
    .pix_ready_o(pix_ready_o), .done_o(done_o), .bitmap_o(bitmap_o),
    .lo_sum_o(lo_sum_o), .lo_cnt_o(lo_cnt_o), .hi_sum_o(hi_sum_o), .hi_cnt_o(hi_cnt_o)
  );

  int vectors = 0;
  int miscmp  = 0;
  int cycles  = 0;
  bit summary_done = 0;

  // behavioural reference model
  int q[$];
  bit m_busy = 0;
  int m_wait = 0;
  bit e_ready = 1, e_done = 0;
  int e_bm = 0, e_lo_sum = 0, e_lo_cnt = 0, e_hi_sum = 0, e_hi_cnt = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_ni) begin
      q.delete(); m_busy = 0; m_wait = 0; e_done = 0;
      e_bm = 0; e_lo_sum = 0; e_lo_cnt = 0; e_hi_sum = 0; e_hi_cnt = 0;
    end else begin
      e_done = 0;
      if (m_busy) begin
        m_wait++;
        if (m_wait == 16) begin
          int s, mn;
          s = 0;
          foreach (q[i]) s += q[i];
          mn = s / 16;
          e_bm = 0; e_lo_sum = 0; e_lo_cnt = 0; e_hi_sum = 0; e_hi_cnt = 0;
          foreach (q[i]) begin
            if (q[i] >= mn) begin e_bm |= (1 << i); e_hi_sum += q[i]; e_hi_cnt++; end
            else begin e_lo_sum += q[i]; e_lo_cnt++; end
          end
          q.delete();
          m_busy = 0;
          e_done = 1;
        end
      end else if (pix_valid_i) begin
        q.push_back(int'(pix_i));
        if (q.size() == 16) begin m_busy = 1; m_wait = 0; end
      end
    end
    e_ready = !m_busy;
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      vectors++;
      if (pix_ready_o !== e_ready) begin
        miscmp++; $display("FAIL R5/R7 ready: got %0b exp %0b", pix_ready_o, e_ready);
      end
      if (done_o !== e_done) begin
        miscmp++; $display("FAIL R6 done: got %0b exp %0b", done_o, e_done);
      end
      if (bitmap_o !== 16'(e_bm)) begin
        miscmp++; $display("FAIL R2/R3 bitmap: got %h exp %h", bitmap_o, 16'(e_bm));
      end
      if (lo_sum_o !== 12'(e_lo_sum) || lo_cnt_o !== 5'(e_lo_cnt)) begin
        miscmp++; $display("FAIL R4 lo: got %0d/%0d exp %0d/%0d", lo_sum_o, lo_cnt_o, e_lo_sum, e_lo_cnt);
      end
      if (hi_sum_o !== 12'(e_hi_sum) || hi_cnt_o !== 5'(e_hi_cnt)) begin
        miscmp++; $display("FAIL R4 hi: got %0d/%0d exp %0d/%0d", hi_sum_o, hi_cnt_o, e_hi_sum, e_hi_cnt);
      end
    end
    if (cycles > 100000) begin
      miscmp++; $display("FAIL watchdog: got %0d cycles exp <= 100000", cycles);
      summary();
    end
  end

  task automatic send(input logic [7:0] p);
    @(negedge clk);
    pix_valid_i = 1'b1; pix_i = p;
    while (!pix_ready_o) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); pix_valid_i = 1'b0; end
  endtask

  task automatic send_block(input logic [7:0] b [16], input bit gaps);
    for (int i = 0; i < 16; i++) begin
      send(b[i]);
      if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 3);
    end
  endtask

  // R5: junk strobes while the encoder is busy must not enter any block
  task automatic junk_while_busy();
    @(negedge clk);
    while (!pix_ready_o) begin
      pix_valid_i = 1'b1; pix_i = 8'($urandom);
      @(negedge clk);
    end
    pix_valid_i = 1'b0;
  endtask

  initial begin
    logic [7:0] blk [16];
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    vectors++;
    if (pix_ready_o !== 1'b1 || done_o !== 1'b0 || bitmap_o !== '0 ||
        lo_sum_o !== '0 || hi_sum_o !== '0 || lo_cnt_o !== '0 || hi_cnt_o !== '0) begin
      miscmp++; $display("FAIL R1 reset: got rdy=%0b done=%0b bm=%h exp 1 0 0", pix_ready_o, done_o, bitmap_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // R2: flat block, all on the mean -> all 1
    foreach (blk[i]) blk[i] = 8'd100;
    send_block(blk, 0); idle(20);
    // R2: full-scale block, 12-bit sum 4080
    foreach (blk[i]) blk[i] = 8'd255;
    send_block(blk, 0); idle(20);
    foreach (blk[i]) blk[i] = 8'd0;
    send_block(blk, 0); idle(20);
    // R2: truncation vs rounding, mean 10.94 -> 10
    foreach (blk[i]) blk[i] = 8'd10;
    blk[15] = 8'd25;
    send_block(blk, 0); idle(20);
    // R3: lone outlier in the last position
    foreach (blk[i]) blk[i] = 8'd0;
    blk[15] = 8'd255;
    send_block(blk, 0); idle(20);
    // R3/R4: ramp
    foreach (blk[i]) blk[i] = 8'(i * 16);
    send_block(blk, 0);
    junk_while_busy();
    // R8: gaps inside blocks, junk between
    for (int k = 0; k < 6; k++) begin
      foreach (blk[i]) blk[i] = 8'($urandom);
      send_block(blk, 1);
      junk_while_busy();
    end
    // R7/R8: back-to-back blocks with valid held high
    for (int k = 0; k < 20; k++) begin
      foreach (blk[i]) blk[i] = 8'($urandom % (k + 2) * 8);
      send_block(blk, 0);
    end
    idle(30);
    summary();
  end
endmodule